// File: doc/BRIEF.md
# Cascadable Synchronous Up-Counter

This block is a wide binary up-counter assembled from identical 4-bit slices. Each slice holds four state bits. On each rising clock edge a slice can take in a parallel word, step up by one, or keep its value. An active-low clear empties every slice at once, without waiting for the clock. The top module chains a parameterised number of slices. The terminal-count output of each slice drives the trickle enable of the slice above it. The whole chain therefore counts as one binary number with a single carry-out.

Each slice chooses its operation for the coming edge through a small decoded mode with three states:

- `OP_LOAD` is chosen whenever the active-low load input is low, whatever the enables are doing.
- `OP_COUNT` is chosen when load is inactive and both the parallel enable and the trickle enable are high.
- `OP_HOLD` is chosen in every other case.

The mode is recomputed every cycle, so any state can follow any other. The clear acts outside this decode.

The parallel enable is shared by every slice. The trickle enable enters only the lowest slice. The carry-out is high when that trickle enable is high and every state bit is one. It follows the trickle enable within the same cycle, with no register in between, so a further chain can be stacked on top.

Top module: `casc_counter`

## Requirements
- R1: While `clr_n` is low, `q` is all zeros. The clear takes effect at once, without a clock edge, and overrides load and both enables.
- R2: With `clr_n` high and `load_n` low at a rising edge, `q` takes the value of `din` on that edge, whatever the levels of `en_par` and `en_trk`.
- R3: With `load_n` high and both `en_par` and `en_trk` high at a rising edge, `q` increases by exactly one on that edge.
- R4: With `load_n` high and at least one of `en_par`/`en_trk` low at a rising edge, `q` keeps its value.
- R5: Counting from the all-ones value wraps `q` to zero.
- R6: `carry_out` is 1 exactly when `en_trk` is 1 and every bit of `q` is 1. It changes within the same cycle as `en_trk`, with no clock edge needed.
- R7: A slice advances only when every lower slice is at 4'b1111. So 0x00F counts to 0x010 and 0x0FF counts to 0x100.
- R8: `en_par` does not gate `carry_out`. With `en_par` low, `en_trk` high and `q` all ones, `carry_out` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| din | input | NUM_SLICES*4 | Parallel load word |
| en_par | input | 1 | Parallel count enable, shared by all slices |
| en_trk | input | 1 | Trickle count enable into the lowest slice |
| q | output | NUM_SLICES*4 | Counter value |
| carry_out | output | 1 | Terminal count of the highest slice |

## Verification
The checker verifies on every cycle that:

- `q` is zero under clear.
- A load lands on the next edge.
- A counting edge adds exactly one, wrap included.
- A non-counting edge leaves `q` unchanged.
- `carry_out` agrees with `en_trk` and the all-ones state.

Some behaviour appears only in the bench's scenarios:

- The clear acting between clock edges.
- Carries moving from one slice into the next at the 0x00F and 0x0FF boundaries.
- The carry-out following `en_trk` within a cycle.
- The carry-out ignoring `en_par`.

// File: rtl/casc_pkg.sv
package casc_pkg;

    localparam int SLICE_W = 4;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2
    } slice_op_e;

endpackage

// File: rtl/slice_ctrl.sv
module slice_ctrl
    import casc_pkg::*;
(
    input  logic      load_n,
    input  logic      en_par,
    input  logic      en_trk,
    output slice_op_e op
);

    // Load outranks both enables (R2); counting needs both enables (R3).
    always_comb begin
        if (!load_n) begin
            op = OP_LOAD;
        end else if (en_par && en_trk) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/slice_reg.sv
module slice_reg
    import casc_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic         clk,
    input  logic         clr_n,
    input  slice_op_e    op,
    input  logic [W-1:0] din,
    output logic [W-1:0] st
);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st <= '0;
        end else begin
            unique case (op)
                OP_LOAD:  st <= din;
                OP_COUNT: st <= st + W'(1);
                OP_HOLD:  st <= st;
                default:  st <= st;
            endcase
        end
    end

endmodule

// File: rtl/slice_tc.sv
module slice_tc #(
    parameter int W = 4
) (
    input  logic [W-1:0] st,
    input  logic         en_trk,
    output logic         tc
);

    always_comb begin
        tc = en_trk && (&st);
    end

endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
    import casc_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic [W-1:0] din,
    input  logic         en_par,
    input  logic         en_trk,
    output logic [W-1:0] q,
    output logic         tc
);

    slice_op_e    op;
    logic [W-1:0] st;

    slice_ctrl u_ctrl (
        .load_n (load_n),
        .en_par (en_par),
        .en_trk (en_trk),
        .op     (op)
    );

    slice_reg #(.W(W)) u_reg (
        .clk   (clk),
        .clr_n (clr_n),
        .op    (op),
        .din   (din),
        .st    (st)
    );

    slice_tc #(.W(W)) u_tc (
        .st     (st),
        .en_trk (en_trk),
        .tc     (tc)
    );

    assign q = st;

endmodule

// File: rtl/casc_counter.sv
module casc_counter
    import casc_pkg::*;
#(
    parameter int NUM_SLICES = 3
) (
    input  logic                          clk,
    input  logic                          clr_n,
    input  logic                          load_n,
    input  logic [NUM_SLICES*SLICE_W-1:0] din,
    input  logic                          en_par,
    input  logic                          en_trk,
    output logic [NUM_SLICES*SLICE_W-1:0] q,
    output logic                          carry_out
);

    localparam int TOTAL_W = NUM_SLICES * SLICE_W;

    // trk[s] is the trickle enable of slice s; trk[NUM_SLICES] is the carry-out.
    logic [NUM_SLICES:0] trk;

    assign trk[0] = en_trk;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        cnt_slice #(.W(SLICE_W)) u_slice (
            .clk    (clk),
            .clr_n  (clr_n),
            .load_n (load_n),
            .din    (din[s*SLICE_W +: SLICE_W]),
            .en_par (en_par),
            .en_trk (trk[s]),
            .q      (q[s*SLICE_W +: SLICE_W]),
            .tc     (trk[s+1])
        );
    end

    assign carry_out = trk[NUM_SLICES];

endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
    parameter int TOTAL_W = 12
) (
    input logic               clk,
    input logic               clr_n,
    input logic               load_n,
    input logic [TOTAL_W-1:0] din,
    input logic               en_par,
    input logic               en_trk,
    input logic [TOTAL_W-1:0] q,
    input logic               carry_out
);

    // R1
    clear_chk: assert property (@(posedge clk) !clr_n |-> (q == '0));

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> (q == $past(din)));

    // R3 R5
    count_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trk) |=> (q == TOTAL_W'($past(q) + 1'b1)));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_par && en_trk)) |=> $stable(q));

    // R6
    carry_chk: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out == (en_trk && (q == {TOTAL_W{1'b1}})));

endmodule

bind casc_counter casc_counter_chk #(.TOTAL_W(TOTAL_W)) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .din       (din),
    .en_par    (en_par),
    .en_trk    (en_trk),
    .q         (q),
    .carry_out (carry_out)
);

// File: tb/casc_counter_test.sv
module casc_counter_test;

    localparam int NS = 3;
    localparam int TW = NS * 4;
    localparam int MAXV = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          clr_n = 1'b0;
    logic          load_n = 1'b1;
    logic [TW-1:0] din = '0;
    logic          en_par = 1'b0;
    logic          en_trk = 1'b0;
    logic [TW-1:0] q;
    logic          carry_out;

    int checks = 0;
    int failures = 0;

    casc_counter #(.NUM_SLICES(NS)) uut (
        .clk       (clk),
        .clr_n     (clr_n),
        .load_n    (load_n),
        .din       (din),
        .en_par    (en_par),
        .en_trk    (en_trk),
        .q         (q),
        .carry_out (carry_out)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One edge, then sample 2 ns later.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic load_val(input int v);
        load_n = 1'b0;
        din = TW'(v);
        tick();
        load_n = 1'b1;
    endtask

    task automatic t_reset();
        #2;
        check("R1 reset q", int'(q), 0);
        check("R1 reset carry", int'(carry_out), 0);
        @(negedge clk);
        clr_n = 1'b1;
        #1;
    endtask

    task automatic t_load();
        en_par = 1'b0; en_trk = 1'b0;
        load_val(32'hA5C);
        check("R2 load enables low", int'(q), 32'hA5C);
        en_par = 1'b1; en_trk = 1'b1;
        load_val(32'h123);
        check("R2 load beats count", int'(q), 32'h123);
        en_par = 1'b0; en_trk = 1'b0;
    endtask

    task automatic t_count();
        int ref_v;
        load_val(32'h00E);
        ref_v = 32'h00E;
        en_par = 1'b1; en_trk = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            ref_v = (ref_v + 1) & MAXV;
            check("R3 R7 count step", int'(q), ref_v);
        end
        en_par = 1'b0; en_trk = 1'b0;
    endtask

    task automatic t_hold();
        load_val(32'h456);
        en_par = 1'b0; en_trk = 1'b1;
        tick();
        check("R4 hold en_par low", int'(q), 32'h456);
        en_par = 1'b1; en_trk = 1'b0;
        tick();
        check("R4 hold en_trk low", int'(q), 32'h456);
        en_par = 1'b0;
    endtask

    task automatic t_wrap();
        load_val(MAXV);
        en_par = 1'b0; en_trk = 1'b1;
        #1;
        check("R8 carry with en_par low", int'(carry_out), 1);
        en_trk = 1'b0;
        #1;
        check("R6 carry drops with en_trk", int'(carry_out), 0);
        en_trk = 1'b1;
        #1;
        check("R6 carry rises with en_trk", int'(carry_out), 1);
        en_par = 1'b1;
        tick();
        check("R5 wrap to zero", int'(q), 0);
        check("R6 carry low after wrap", int'(carry_out), 0);
        en_par = 1'b0; en_trk = 1'b0;
    endtask

    task automatic t_chain();
        load_val(32'h0FF);
        en_par = 1'b1; en_trk = 1'b1;
        tick();
        check("R7 carry into top slice", int'(q), 32'h100);
        en_par = 1'b0;
        load_val(32'h7FF);
        en_trk = 1'b1;
        #1;
        check("R6 no carry below max", int'(carry_out), 0);
        en_trk = 1'b0;
    endtask

    task automatic t_async();
        load_val(32'h9AB);
        @(negedge clk);
        clr_n = 1'b0;
        #1;
        check("R1 clear without edge", int'(q), 0);
        load_n = 1'b0; din = TW'(32'h777);
        en_par = 1'b1; en_trk = 1'b1;
        tick();
        check("R1 clear beats load", int'(q), 0);
        load_n = 1'b1;
        @(negedge clk);
        clr_n = 1'b1;
        tick();
        check("R3 count after clear", int'(q), 1);
        en_par = 1'b0; en_trk = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_count();
        t_hold();
        t_wrap();
        t_chain();
        t_async();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule